// File: doc/BRIEF.md
# Supply Monitor Control Block

This block is the digital side of a supply monitor. It sits behind a simple byte-wide read/write bus and exposes two registers. One covers the detect level, which can raise an interrupt and request a system reset. The other covers the warning level, which can only raise an interrupt. Two comparators outside the block report whether the supply is below each trip point. Their outputs arrive already synchronized to `clk`. The block turns them into sticky flags and drives the trip-level select codes back out to the comparators.

Software acknowledges an event by writing 1 to the acknowledge bit of the matching register. The reset-enable bit can be written only once after each reset. While the low-power input is high, monitoring is suspended. There are two asynchronous resets. Power-on reset clears everything. Chip reset clears everything except the two trip-select codes.

Top module: `supmon_ctrl`

## Requirements
- R1: After power-on reset, the detect register (offset 0) reads 0x10 and the warning register (offset 1) reads 0x00. Both select outputs read 0, and both interrupt outputs and the reset request are low.
- R2: Layout of the detect register: bits [1:0] select, bit 4 reset enable, bit 5 interrupt enable, bit 6 acknowledge, bit 7 flag. Layout of the warning register: bits [1:0] select, bit 5 interrupt enable, bit 6 acknowledge, bit 7 flag. All other bits read 0. A write takes effect at the next rising edge. Read data is valid combinationally while `bus_en`=1 and `bus_we`=0, and is 0 otherwise.
- R3: The first write to the detect register after either reset loads the reset-enable bit. Later writes leave that bit unchanged until the next reset.
- R4: Writing 1 to an acknowledge bit clears the matching flag at the next edge. Acknowledge bits always read 0.
- R5: A flag is set at the first rising edge at which its below-threshold input is high and low-power is low. This includes the first edge after a reset is released.
- R6: If a flag is set and acknowledged at the same edge, the flag ends up 1.
- R7: `det_irq` = detect flag AND its interrupt enable. `warn_irq` = warning flag AND its interrupt enable. `sys_rst_req` = detect flag AND reset enable.
- R8: A write of detect select code 2 or 3 leaves the detect select field unchanged. The warning select accepts all four codes.
- R9: While `lowpwr`=1, no flag is set, whatever the below-threshold inputs are.
- R10: Chip reset clears every register bit except the two select fields. Power-on reset clears the select fields as well.
- R11: Offsets other than 0 and 1 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| crst_n | input | 1 | Chip reset, asynchronous, active low |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| below_det | input | 1 | Supply below the detect trip point |
| below_warn | input | 1 | Supply below the warning trip point |
| lowpwr | input | 1 | Very-low-power mode, suspends monitoring |
| det_sel | output | 2 | Detect trip-level code to the comparator |
| warn_sel | output | 2 | Warning trip-level code to the comparator |
| det_irq | output | 1 | Detect interrupt request |
| warn_irq | output | 1 | Warning interrupt request |
| sys_rst_req | output | 1 | System reset request |

## Verification
Read data is combinational, so a read is due in the same cycle it is driven. A write, a comparator input or the release of a reset shows up after exactly one rising edge. The interrupt and reset-request outputs follow the registers with no further delay.

The bench drives every input at a falling edge. Each expected read value is queued when the read is issued. A monitor compares that value one nanosecond after the same falling edge, so it sees the state left by the preceding rising edge. Direct output checks wait one nanosecond after a falling edge and then realign to the next one, which keeps them clear of asynchronous reset updates.

// File: rtl/supmon_pkg.sv
`timescale 1ns/1ps
package supmon_pkg;
   // register byte width and field placement; software decodes these positions
   localparam int unsigned REG_W    = 8;
   localparam int unsigned SEL_W    = 2;
   localparam int unsigned BIT_RE   = 4;
   localparam int unsigned BIT_IE   = 5;
   localparam int unsigned BIT_ACK  = 6;
   localparam int unsigned BIT_FLAG = 7;
   // channel indices
   localparam int unsigned NUM_CH   = 2;
   localparam int unsigned CH_DET   = 0;
   localparam int unsigned CH_WARN  = 1;
endpackage

// File: rtl/supmon_flag.sv
`timescale 1ns/1ps
// Sticky event flag: hardware set has priority over the acknowledge clear.
module supmon_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic mon_en,
   input  logic below,
   input  logic ack,
   output logic flag_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= (mon_en & below) | (flag_q & ~ack);
   end
endmodule

// File: rtl/supmon_selreg.sv
`timescale 1ns/1ps
// Trip-level select field, cleared only by power-on reset.
// Codes above MAX_CODE are rejected and the field keeps its value.
module supmon_selreg #(
   parameter int unsigned W        = 2,
   parameter int unsigned MAX_CODE = 3
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam int unsigned FULL = (1 << W) - 1;

   if (MAX_CODE > FULL) begin : g_bad_max
      $error("supmon_selreg: MAX_CODE does not fit in W bits");
   end

   logic legal;
   if (MAX_CODE == FULL) begin : g_all_legal
      assign legal = 1'b1;
   end else begin : g_limited
      assign legal = ({{(32-W){1'b0}}, d} <= MAX_CODE);
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)          q <= '0;
      else if (we && legal) q <= d;
   end
endmodule

// File: rtl/supmon_wonce.sv
`timescale 1ns/1ps
// Bit that accepts the first write after reset, then locks.
module supmon_wonce #(
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic we,
   input  logic d,
   output logic q,
   output logic locked
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q      <= RST_VAL;
         locked <= 1'b0;
      end else if (we && !locked) begin
         q      <= d;
         locked <= 1'b1;
      end
   end
endmodule

// File: rtl/supmon_ctrl.sv
`timescale 1ns/1ps
module supmon_ctrl
   import supmon_pkg::*;
#(
   parameter int unsigned ADDR_W       = 4,
   parameter int unsigned DET_ADDR     = 0,
   parameter int unsigned WARN_ADDR    = 1,
   parameter int unsigned DET_SEL_MAX  = 1,
   parameter int unsigned WARN_SEL_MAX = 3,
   parameter bit          RE_RST       = 1'b1
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              crst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic [REG_W-1:0]  bus_rdata,
   input  logic              below_det,
   input  logic              below_warn,
   input  logic              lowpwr,
   output logic [SEL_W-1:0]  det_sel,
   output logic [SEL_W-1:0]  warn_sel,
   output logic              det_irq,
   output logic              warn_irq,
   output logic              sys_rst_req
);
   localparam int unsigned ADDR_SPAN = 1 << ADDR_W;

   // elaboration checks
   if (DET_ADDR == WARN_ADDR) begin : g_bad_overlap
      $error("supmon_ctrl: register offsets collide");
   end
   if (DET_ADDR >= ADDR_SPAN || WARN_ADDR >= ADDR_SPAN) begin : g_bad_range
      $error("supmon_ctrl: offset outside address space");
   end
   if (SEL_W != 2 || REG_W != 8) begin : g_bad_layout
      $error("supmon_ctrl: field layout assumes byte registers with 2-bit selects");
   end

   // combined reset for everything but the select fields
   logic rst_all_n;
   assign rst_all_n = por_n & crst_n;

   logic              mon_en;
   logic [NUM_CH-1:0] below_v;
   logic [NUM_CH-1:0] hit;
   logic [NUM_CH-1:0] wr_hit;
   logic [NUM_CH-1:0] ack_v;
   logic [NUM_CH-1:0] flag_q;
   logic [NUM_CH-1:0] ie_q;
   logic [NUM_CH-1:0][SEL_W-1:0] sel_q;
   logic [NUM_CH-1:0][REG_W-1:0] rd_word;
   logic re_q;
   logic re_lock;

   assign mon_en  = ~lowpwr;
   assign below_v = {below_warn, below_det};

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam int unsigned OFFS = (c == CH_DET) ? DET_ADDR : WARN_ADDR;
      localparam int unsigned SMAX = (c == CH_DET) ? DET_SEL_MAX : WARN_SEL_MAX;

      assign hit[c]    = bus_en && ({{(32-ADDR_W){1'b0}}, bus_addr} == OFFS);
      assign wr_hit[c] = hit[c] & bus_we;
      assign ack_v[c]  = wr_hit[c] & bus_wdata[BIT_ACK];

      supmon_flag u_flag (
         .clk    (clk),
         .rst_n  (rst_all_n),
         .mon_en (mon_en),
         .below  (below_v[c]),
         .ack    (ack_v[c]),
         .flag_q (flag_q[c])
      );

      supmon_selreg #(.W(SEL_W), .MAX_CODE(SMAX)) u_sel (
         .clk   (clk),
         .por_n (por_n),
         .we    (wr_hit[c]),
         .d     (bus_wdata[SEL_W-1:0]),
         .q     (sel_q[c])
      );

      always_ff @(posedge clk or negedge rst_all_n) begin
         if (!rst_all_n)    ie_q[c] <= 1'b0;
         else if (wr_hit[c]) ie_q[c] <= bus_wdata[BIT_IE];
      end

      // readback word; acknowledge and reserved bits stay zero
      always_comb begin
         rd_word[c]              = '0;
         rd_word[c][SEL_W-1:0]   = sel_q[c];
         rd_word[c][BIT_IE]      = ie_q[c];
         rd_word[c][BIT_FLAG]    = flag_q[c];
         if (c == CH_DET) rd_word[c][BIT_RE] = re_q;
      end
   end

   // reset enable exists on the detect channel only
   supmon_wonce #(.RST_VAL(RE_RST)) u_re (
      .clk    (clk),
      .rst_n  (rst_all_n),
      .we     (wr_hit[CH_DET]),
      .d      (bus_wdata[BIT_RE]),
      .q      (re_q),
      .locked (re_lock)
   );

   always_comb begin
      bus_rdata = '0;
      if (!bus_we) begin
         for (int c = 0; c < NUM_CH; c++) begin
            if (hit[c]) bus_rdata = rd_word[c];
         end
      end
   end

   assign det_sel     = sel_q[CH_DET];
   assign warn_sel    = sel_q[CH_WARN];
   assign det_irq     = flag_q[CH_DET]  & ie_q[CH_DET];
   assign warn_irq    = flag_q[CH_WARN] & ie_q[CH_WARN];
   assign sys_rst_req = flag_q[CH_DET]  & re_q;

   logic unused_wbits;
   assign unused_wbits = ^{bus_wdata[BIT_RE-1:SEL_W], bus_wdata[BIT_FLAG]};
endmodule

// File: rtl/supmon_ctrl_chk.sv
`timescale 1ns/1ps
module supmon_ctrl_chk
   import supmon_pkg::*;
#(
   parameter int unsigned DET_SEL_MAX = 1
) (
   input logic              clk,
   input logic              por_n,
   input logic              rst_all_n,
   input logic              lowpwr,
   input logic              below_det,
   input logic              below_warn,
   input logic [NUM_CH-1:0] flag_q,
   input logic [NUM_CH-1:0] ack_v,
   input logic [NUM_CH-1:0] wr_hit,
   input logic              re_q,
   input logic              re_lock,
   input logic [REG_W-1:0]  bus_wdata,
   input logic [REG_W-1:0]  bus_rdata,
   input logic [SEL_W-1:0]  det_sel
);
   // R5: comparator high while monitoring -> flag next edge
   a_r5_det_set: assert property (@(posedge clk) disable iff (!rst_all_n)
      (below_det && !lowpwr) |=> flag_q[CH_DET]);
   a_r5_warn_set: assert property (@(posedge clk) disable iff (!rst_all_n)
      (below_warn && !lowpwr) |=> flag_q[CH_WARN]);

   // R9: no flag rises while low-power
   a_r9_det_hold: assert property (@(posedge clk) disable iff (!rst_all_n)
      (lowpwr && !flag_q[CH_DET]) |=> !flag_q[CH_DET]);
   a_r9_warn_hold: assert property (@(posedge clk) disable iff (!rst_all_n)
      (lowpwr && !flag_q[CH_WARN]) |=> !flag_q[CH_WARN]);

   // R4: acknowledge clears when no new event
   a_r4_det_ack: assert property (@(posedge clk) disable iff (!rst_all_n)
      (ack_v[CH_DET] && !(below_det && !lowpwr)) |=> !flag_q[CH_DET]);
   a_r4_ack_reads0: assert property (@(posedge clk) disable iff (!rst_all_n)
      !bus_rdata[BIT_ACK]);

   // R3: once locked the reset enable holds
   a_r3_once: assert property (@(posedge clk) disable iff (!rst_all_n)
      re_lock |=> $stable(re_q));

   // R8: reserved detect codes leave the select unchanged
   a_r8_reserved: assert property (@(posedge clk) disable iff (!por_n)
      (wr_hit[CH_DET] && ({30'd0, bus_wdata[SEL_W-1:0]} > DET_SEL_MAX)) |=> $stable(det_sel));
endmodule

bind supmon_ctrl supmon_ctrl_chk #(.DET_SEL_MAX(DET_SEL_MAX)) u_chk (
   .clk        (clk),
   .por_n      (por_n),
   .rst_all_n  (rst_all_n),
   .lowpwr     (lowpwr),
   .below_det  (below_det),
   .below_warn (below_warn),
   .flag_q     (flag_q),
   .ack_v      (ack_v),
   .wr_hit     (wr_hit),
   .re_q       (re_q),
   .re_lock    (re_lock),
   .bus_wdata  (bus_wdata),
   .bus_rdata  (bus_rdata),
   .det_sel    (det_sel)
);

// File: tb/supmon_ctrl_test.sv
`timescale 1ns/1ps
module supmon_ctrl_test;
   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       crst_n = 1'b0;
   logic       bus_en = 1'b0;
   logic       bus_we = 1'b0;
   logic [3:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       below_det = 1'b0;
   logic       below_warn = 1'b0;
   logic       lowpwr = 1'b0;
   logic [1:0] det_sel;
   logic [1:0] warn_sel;
   logic       det_irq;
   logic       warn_irq;
   logic       sys_rst_req;

   int checks = 0;
   int fails  = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #2.5 clk = ~clk;

   supmon_ctrl uut (
      .clk(clk), .por_n(por_n), .crst_n(crst_n),
      .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .below_det(below_det), .below_warn(below_warn), .lowpwr(lowpwr),
      .det_sel(det_sel), .warn_sel(warn_sel),
      .det_irq(det_irq), .warn_irq(warn_irq), .sys_rst_req(sys_rst_req)
   );

   task automatic judge(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
      end
   endtask

   // monitor: compares read data against the scoreboard
   always @(negedge clk) begin
      #1;
      if (bus_en && !bus_we) begin
         if (exp_q.size() == 0) begin
            judge(1'b0, "unexpected read", bus_rdata, 8'h00);
         end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            judge(bus_rdata === e, t, bus_rdata, e);
         end
      end
   end

   // driver tasks: called at a falling edge, return at the next one
   task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      bus_en = 1'b0;
   endtask

   task automatic chk(input logic [7:0] act_unused, input logic [7:0] exp, input string tag,
                      input int sel);
      logic [7:0] act;
      #1;
      case (sel)
         0: act = {7'd0, det_irq};
         1: act = {7'd0, warn_irq};
         2: act = {7'd0, sys_rst_req};
         3: act = {6'd0, det_sel};
         default: act = {6'd0, warn_sel};
      endcase
      judge(act === exp, tag, act, exp);
      if (act_unused === 8'hxx) checks = checks;
      @(negedge clk);
   endtask

   localparam int O_DIRQ = 0, O_WIRQ = 1, O_RST = 2, O_DSEL = 3, O_WSEL = 4;

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      #1000000;
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      por_n = 1'b1; crst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      bus_rd(4'd0, 8'h10, "R1 detect reset value");
      bus_rd(4'd1, 8'h00, "R1 warning reset value");
      chk(8'h0, 8'd0, "R1 det_irq low", O_DIRQ);
      chk(8'h0, 8'd0, "R1 sys_rst_req low", O_RST);
      chk(8'h0, 8'd0, "R1 det_sel zero", O_DSEL);

      // R2 / R3 first write loads reset enable = 0
      bus_wr(4'd0, 8'h21);
      bus_rd(4'd0, 8'h21, "R2 R3 detect write stored");
      chk(8'h0, 8'd1, "R2 det_sel driven", O_DSEL);
      // R8 reserved code 3 rejected, R3 reset enable locked
      bus_wr(4'd0, 8'h33);
      bus_rd(4'd0, 8'h21, "R8 R3 reserved code and locked enable");
      chk(8'h0, 8'd1, "R8 det_sel unchanged", O_DSEL);
      bus_wr(4'd0, 8'h20);
      bus_rd(4'd0, 8'h20, "R8 legal code 0 accepted");
      bus_wr(4'd0, 8'h21);

      // R2 R8 warning accepts code 3, reserved bits drop
      bus_wr(4'd1, 8'hFF);
      bus_rd(4'd1, 8'h23, "R2 R8 warning write stored");
      chk(8'h0, 8'd3, "R8 warn_sel code 3", O_WSEL);

      // R5 R7 warning event
      below_warn = 1'b1;
      @(negedge clk);
      below_warn = 1'b0;
      bus_rd(4'd1, 8'hA3, "R5 warning flag set");
      chk(8'h0, 8'd1, "R7 warn_irq high", O_WIRQ);

      // R4 acknowledge
      bus_wr(4'd1, 8'h63);
      bus_rd(4'd1, 8'h23, "R4 acknowledge clears warning flag");
      chk(8'h0, 8'd0, "R4 warn_irq dropped", O_WIRQ);

      // R6 set beats acknowledge
      below_warn = 1'b1;
      bus_wr(4'd1, 8'h63);
      below_warn = 1'b0;
      bus_rd(4'd1, 8'hA3, "R6 set wins over acknowledge");
      bus_wr(4'd1, 8'h63);
      bus_rd(4'd1, 8'h23, "R4 later acknowledge clears");

      // R7 interrupt gated by enable
      bus_wr(4'd1, 8'h03);
      below_warn = 1'b1;
      @(negedge clk);
      below_warn = 1'b0;
      bus_rd(4'd1, 8'h83, "R5 flag with interrupt disabled");
      chk(8'h0, 8'd0, "R7 warn_irq gated by enable", O_WIRQ);
      bus_wr(4'd1, 8'h43);
      bus_rd(4'd1, 8'h03, "R4 acknowledge with enable off");

      // R9 low-power suspends monitoring
      lowpwr = 1'b1; below_det = 1'b1;
      repeat (3) @(negedge clk);
      bus_rd(4'd0, 8'h21, "R9 no flag in low power");
      chk(8'h0, 8'd0, "R9 det_irq stays low", O_DIRQ);
      lowpwr = 1'b0;
      @(negedge clk);
      bus_rd(4'd0, 8'hA1, "R5 detect flag after low power ends");
      chk(8'h0, 8'd1, "R7 det_irq high", O_DIRQ);
      chk(8'h0, 8'd0, "R7 no reset request with enable 0", O_RST);

      // R10 chip reset keeps selects, R5 flag re-set after reset
      crst_n = 1'b0;
      chk(8'h0, 8'd0, "R10 det_irq cleared by chip reset", O_DIRQ);
      crst_n = 1'b1;
      @(negedge clk);
      bus_rd(4'd0, 8'h91, "R10 R5 detect after chip reset");
      bus_rd(4'd1, 8'h03, "R10 warning select survives");
      chk(8'h0, 8'd1, "R7 sys_rst_req asserted", O_RST);
      chk(8'h0, 8'd1, "R10 det_sel survives", O_DSEL);
      chk(8'h0, 8'd3, "R10 warn_sel survives", O_WSEL);

      // R3 relock after reset, R4 ack
      below_det = 1'b0;
      bus_wr(4'd0, 8'h40);
      bus_rd(4'd0, 8'h00, "R3 R4 first write after reset");
      chk(8'h0, 8'd0, "R7 sys_rst_req released", O_RST);
      bus_wr(4'd0, 8'h10);
      bus_rd(4'd0, 8'h00, "R3 second write ignored");

      // R11 unmapped offset
      bus_wr(4'd5, 8'hFF);
      bus_rd(4'd5, 8'h00, "R11 unmapped reads zero");
      bus_rd(4'd0, 8'h00, "R11 detect untouched");
      bus_rd(4'd1, 8'h03, "R11 warning untouched");

      // R10 power-on reset clears selects
      por_n = 1'b0;
      @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);
      bus_rd(4'd0, 8'h10, "R10 R1 detect after power-on reset");
      bus_rd(4'd1, 8'h00, "R10 R1 warning after power-on reset");
      chk(8'h0, 8'd0, "R10 warn_sel cleared", O_WSEL);

      repeat (2) @(negedge clk);
      if (exp_q.size() != 0) judge(1'b0, "scoreboard not drained", 8'(exp_q.size()), 8'h00);
      finish_run();
   end
endmodule